// File: doc/BRIEF.md
# Burst Access Address Generator

This block is the address front end of one port of a synchronous memory. On every rising clock edge it picks the address for the current access. The address comes either from an external input or from an internal counter, and the choice is set by three active-low controls: a clear, a strobe and a step enable. The chosen address appears combinationally on `access_addr` in the same cycle, so a read or write can run in the same cycle as a load, an increment or a clear. There is no dead cycle for any of the three.

The counter register captures the address used in each cycle. A burst therefore starts with one strobed external address and continues by stepping. Stepping can be paused by holding. While holding, the external address input is not looked at. The counter covers the full 13-bit address space and wraps from the top word back to word 0. Chip selection is handled elsewhere and has no effect on this block.

The controls have a fixed order of precedence. Clear wins over strobe, strobe wins over step, and step wins over hold.

Top module: `burst_addr_gen`

## Requirements
- R1: When `zero_n` is 0, `access_addr` is 0 in that same cycle, and after the edge the counter holds 0.
- R2: `zero_n` = 0 takes precedence: the result is the same whatever `strobe_n`, `step_n` and `ext_addr` are.
- R3: When `zero_n` = 1 and `strobe_n` = 0, `access_addr` equals `ext_addr` in that cycle, and the counter takes that value at the edge.
- R4: When `zero_n` = 1, `strobe_n` = 1 and `step_n` = 0, `access_addr` is the counter value plus one in that cycle, and the counter takes that value.
- R5: When all three controls are 1, `access_addr` equals the counter value, the counter is unchanged, and `ext_addr` has no effect.
- R6: `step_n` has no effect while `strobe_n` or `zero_n` is 0.
- R7: Stepping from address 8191 (all ones) gives address 0.
- R8: A synchronous reset (`rst_n` = 0 at an edge) clears the counter, so a hold cycle after reset accesses address 0.
- R9: The counter value in any cycle equals the address accessed in the previous cycle, unless reset was applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset, clears the counter |
| ext_addr | input | 13 | External address, used when strobed |
| strobe_n | input | 1 | Active-low load of the external address |
| step_n | input | 1 | Active-low counter increment |
| zero_n | input | 1 | Active-low counter clear, highest precedence |
| access_addr | output | 13 | Address used for the current access |

## Verification
The bench aims at the precedence cases first. A clear applied together with a strobe and a step must give 0. A design that ranked the controls wrongly would pass the external address or an incremented value instead. A strobe applied together with a step must give the external address and not that address plus one, and a hold with a changing external address must not follow that input. A step from all ones must give 0, not a stuck or widened value. Hold cycles after a clear and after a reset must show 0, which exposes a counter that delays its update by a cycle or skips the clear.

// File: rtl/burst_addr_pkg.sv
// Shared types for the burst access address generator.
package burst_addr_pkg;
    // Operation chosen for one cycle, after precedence is resolved.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2,
        OP_ZERO = 2'd3
    } addr_op_e;
endpackage

// File: rtl/burst_op_decode.sv
// Resolves the three active-low controls into one operation.
// Precedence: clear, then strobe, then step, then hold.
// Assumes the inputs are synchronous to the port clock.
module burst_op_decode
    import burst_addr_pkg::*;
(
    input  logic     strobe_n,
    input  logic     step_n,
    input  logic     zero_n,
    output addr_op_e op
);
    // Priority selection of the current operation.
    always_comb begin
        if (!zero_n)        op = OP_ZERO;
        else if (!strobe_n) op = OP_LOAD;
        else if (!step_n)   op = OP_STEP;
        else                op = OP_HOLD;
    end
endmodule

// File: rtl/burst_addr_next.sv
// Computes the address for this cycle from the operation, the external
// address and the counter. The same value is the counter's next state.
// Increment wraps naturally at the width of the address.
module burst_addr_next
    import burst_addr_pkg::*;
#(
    parameter int AW = 13
) (
    input  addr_op_e        op,
    input  logic [AW-1:0]   ext_addr,
    input  logic [AW-1:0]   cnt_q,
    output logic [AW-1:0]   nxt
);
    localparam logic [AW-1:0] ONE = AW'(1);

    // Select the address for the current access.
    always_comb begin
        unique case (op)
            OP_ZERO: nxt = '0;
            OP_LOAD: nxt = ext_addr;
            OP_STEP: nxt = cnt_q + ONE;
            default: nxt = cnt_q;
        endcase
    end
endmodule

// File: rtl/burst_addr_reg.sv
// Counter register. It captures the address used in each cycle.
// The reset is synchronous and active low, and clears the register to zero.
module burst_addr_reg #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] d,
    output logic [AW-1:0] q
);
    // Register update with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R9
    carry_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> q == $past(d));
endmodule

// File: rtl/burst_addr_gen.sv
// Top of the burst access address generator. It produces the access address
// in the same cycle from a strobed external address or an internal counter.
// Assumes one access per clock. The counter ignores chip selection.
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ext_addr,
    input  logic          strobe_n,
    input  logic          step_n,
    input  logic          zero_n,
    output logic [AW-1:0] access_addr
);
    localparam logic [AW-1:0] TOP_ADDR = {AW{1'b1}};

    addr_op_e      op;
    logic [AW-1:0] cnt_q;
    logic [AW-1:0] nxt;

    burst_op_decode u_dec (
        .strobe_n (strobe_n),
        .step_n   (step_n),
        .zero_n   (zero_n),
        .op       (op)
    );

    burst_addr_next #(.AW(AW)) u_next (
        .op       (op),
        .ext_addr (ext_addr),
        .cnt_q    (cnt_q),
        .nxt      (nxt)
    );

    burst_addr_reg #(.AW(AW)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nxt),
        .q     (cnt_q)
    );

    assign access_addr = nxt;

    // R1
    zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_n |-> access_addr == '0);
    // R3
    load_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_n && !strobe_n) |-> access_addr == ext_addr);
    // R4
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_n && strobe_n && !step_n) |-> access_addr == cnt_q + AW'(1));
    // R5
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_n && strobe_n && step_n) |-> access_addr == cnt_q);
    // R7
    wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_n && strobe_n && !step_n && cnt_q == TOP_ADDR) |-> access_addr == '0);
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          strobe_n = 1'b1;
    logic          step_n = 1'b1;
    logic          zero_n = 1'b1;
    logic [AW-1:0] access_addr;

    int checks = 0;
    int fails = 0;
    logic [AW-1:0] model_cnt = '0;
    bit done = 1'b0;

    burst_addr_gen #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
        .strobe_n(strobe_n), .step_n(step_n), .zero_n(zero_n),
        .access_addr(access_addr)
    );

    always #5 clk = ~clk;

    // Expected address from the precedence rules.
    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] cnt, logic [AW-1:0] ext,
                                               logic s_n, logic e_n, logic z_n);
        if (!z_n)      return '0;
        else if (!s_n) return ext;
        else if (!e_n) return cnt + AW'(1);
        else           return cnt;
    endfunction

    function automatic string tag_of(logic s_n, logic e_n, logic z_n);
        if (!z_n)      return (!s_n || !e_n) ? "R2" : "R1";
        else if (!s_n) return (!e_n) ? "R6" : "R3";
        else if (!e_n) return (model_cnt == '1) ? "R7" : "R4";
        else           return "R5";
    endfunction

    task automatic check(string tag, logic [AW-1:0] exp);
        checks++;
        if (access_addr !== exp) begin
            fails++;
            $display("FAIL %s: access_addr=%0d expected=%0d", tag, access_addr, exp);
        end
    endtask

    // One cycle: drive after the falling edge, sample before the rising edge.
    task automatic cycle(logic [AW-1:0] ext, logic s_n, logic e_n, logic z_n, string tag);
        logic [AW-1:0] e;
        @(negedge clk);
        ext_addr = ext; strobe_n = s_n; step_n = e_n; zero_n = z_n;
        #3;
        e = exp_addr(model_cnt, ext, s_n, e_n, z_n);
        check(tag == "" ? tag_of(s_n, e_n, z_n) : tag, e);
        model_cnt = e;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_cnt = '0;
        // R8: the counter is clear after reset
        cycle(13'h1ABC, 1'b1, 1'b1, 1'b1, "R8");
        // R3 load, then R9 hold gives the loaded value back
        cycle(13'd100, 1'b0, 1'b1, 1'b1, "R3");
        cycle(13'd7, 1'b1, 1'b1, 1'b1, "R9");
        // R4 increment twice, with the external address changing
        cycle(13'd55, 1'b1, 1'b0, 1'b1, "R4");
        cycle(13'd66, 1'b1, 1'b0, 1'b1, "R4");
        // R5 hold ignores ext_addr
        cycle(13'h0FFF, 1'b1, 1'b1, 1'b1, "R5");
        // R6 strobe together with step loads without incrementing
        cycle(13'd500, 1'b0, 1'b0, 1'b1, "R6");
        cycle(13'd0, 1'b1, 1'b1, 1'b1, "R6");
        // R2 clear overrides strobe and step
        cycle(13'd1234, 1'b0, 1'b0, 1'b0, "R2");
        cycle(13'd999, 1'b1, 1'b1, 1'b1, "R1");
        // R7 wrap from the top address
        cycle(13'h1FFF, 1'b0, 1'b1, 1'b1, "R3");
        cycle(13'd3, 1'b1, 1'b0, 1'b1, "R7");
        cycle(13'd3, 1'b1, 1'b0, 1'b1, "R4");
        // R6 clear with step only
        cycle(13'd3, 1'b1, 1'b0, 1'b0, "R6");
        // Random traffic, weighted toward steps and holds.
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic s_n, e_n, z_n;
            r   = $urandom_range(0, 99);
            z_n = (r < 6) ? 1'b0 : 1'b1;
            s_n = ($urandom_range(0, 99) < 20) ? 1'b0 : 1'b1;
            e_n = ($urandom_range(0, 99) < 60) ? 1'b0 : 1'b1;
            if ((i % 400) == 399) begin
                cycle(13'h1FFF, 1'b0, 1'b1, 1'b1, "R3");
            end else begin
                cycle(AW'($urandom), s_n, e_n, z_n, "");
            end
        end
        // R8 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_cnt = '0;
        cycle(13'd42, 1'b1, 1'b1, 1'b1, "R8");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule